// File: doc/BRIEF.md
# Dual-Mode CPU Register Bus Bridge

This block is a slave that connects a strobe-driven, asynchronous 16-bit processor bus to a small internal register array in the system clock domain. It has two bus modes. In split mode the word address arrives on dedicated address pins. In muxed mode the address is carried on the low data lines and captured by an address-latch strobe, which takes over the top address pin. A mode pin is sampled once as reset ends. The mode then holds until the next reset.

Every bus strobe, and the address and data lines, pass through a two-flop synchronizer. Each rising edge of a write strobe becomes a one-cycle write request with a byte-enable mask. Each falling edge of the read strobe becomes a one-cycle read request. The value read back is held on the data output. The output enable follows chip select and the read strobe directly from the pins, so the bus is released as soon as either one goes inactive. A 64-word array with a write enable for each byte sits behind the requests so the whole path can be exercised.

Top module: `cpubus_bridge`

## Requirements
- R1: With the mode pin low at reset (split mode), the word address is bus_a_i[7:1]. A write followed by a read at the same address returns the written word on bus_d_o.
- R2: With the mode pin high at reset (muxed mode), bus_a_i[7] acts as the address latch strobe. On its falling edge the word address is taken from bus_d_i[7:1]. bus_d_i[0] has no effect on the address.
- R3: The mode is captured when reset is released. Changing mode_sel_i afterwards does not change the addressing behaviour.
- R4: While bus_cs_n_i is high, write strobes produce no request and change no word, and bus_d_oe_o stays low.
- R5: bus_d_oe_o is high exactly while bus_cs_n_i and bus_rd_n_i are both low. Otherwise the bus is released.
- R6: A rising edge on bus_wrh_n_i alone writes only bits 15..8 of the addressed word.
- R7: A rising edge on bus_wrl_n_i alone writes only bits 7..0 of the addressed word.
- R8: Each write strobe rising edge makes a one-cycle req_wr_o pulse. req_be_o bit 1 marks the upper byte and bit 0 marks the lower byte. When both strobes rise in the same sample, one pulse is made with req_be_o = 2'b11. req_addr_o and req_wdata_o carry the address and the data.
- R9: In muxed mode the latched address is held until the next latch-strobe falling edge. Every read and write in between uses it.
- R10: Word addresses 64 to 127 still produce requests, but they write nothing and read back as zero.
- R11: After reset every word reads zero and req_wr_o, req_rd_o and bus_d_oe_o are low.
- R12: Each falling edge of bus_rd_n_i while chip select is low makes exactly one one-cycle req_rd_o pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_sel_i | input | 1 | Bus mode: 0 split, 1 muxed; sampled at reset release |
| bus_cs_n_i | input | 1 | Active-low chip select |
| bus_rd_n_i | input | 1 | Active-low read strobe |
| bus_wrh_n_i | input | 1 | Active-low upper-byte write strobe |
| bus_wrl_n_i | input | 1 | Active-low lower-byte write strobe |
| bus_a_i | input | 7 | Address pins [7:1]; bit 7 is the latch strobe in muxed mode |
| bus_d_i | input | 16 | Data bus input (address on [7:1] during latch in muxed mode) |
| bus_d_o | output | 16 | Read data driven toward the bus |
| bus_d_oe_o | output | 1 | Data bus output enable |
| req_wr_o | output | 1 | One-cycle write request |
| req_be_o | output | 2 | Byte enables of the write request |
| req_rd_o | output | 1 | One-cycle read request |
| req_addr_o | output | 7 | Word address of the request |
| req_wdata_o | output | 16 | Write data of the request |

## Verification
The bench uses the default parameters: 8-bit lanes, a 7-bit word address, a depth of 64 and two synchronizer stages. Because the address is one bit wider than the array needs, both the aliasing of out-of-range addresses and the in-range words are reachable. The bench runs each mode in its own reset epoch. This covers the mode-pin capture, reuse of a latched address over several accesses, and random mixes of byte masks over the whole 128-word address space.

// File: rtl/cpubus_pkg.sv
package cpubus_pkg;
  typedef enum logic {
    MODE_SPLIT = 1'b0,
    MODE_MUXED = 1'b1
  } bus_mode_e;
endpackage

// File: rtl/cpubus_sync.sv
module cpubus_sync #(
  parameter int              WIDTH   = 1,
  parameter int              STAGES  = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [STAGES-1:0][WIDTH-1:0] stage_d, stage_q;

  always_comb begin
    stage_d = {stage_q[STAGES-2:0], d_i};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_q <= {STAGES{RST_VAL}};
    else        stage_q <= stage_d;
  end

  assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/cpubus_strobe.sv
module cpubus_strobe (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       en_i,
  input  logic       cs_n_s_i,
  input  logic       rd_n_s_i,
  input  logic       wrh_n_s_i,
  input  logic       wrl_n_s_i,
  input  logic       ale_s_i,
  output logic       wr_o,
  output logic [1:0] be_o,
  output logic       rd_o,
  output logic       ale_fall_o
);
  logic cs_prev_q, rd_prev_q, wrh_prev_q, wrl_prev_q, ale_prev_q;
  logic cs_prev_d, rd_prev_d, wrh_prev_d, wrl_prev_d, ale_prev_d;
  logic hi_rise, lo_rise;

  always_comb begin
    cs_prev_d  = cs_n_s_i;
    rd_prev_d  = rd_n_s_i;
    wrh_prev_d = wrh_n_s_i;
    wrl_prev_d = wrl_n_s_i;
    ale_prev_d = ale_s_i;
    hi_rise    = en_i & ~cs_prev_q & wrh_n_s_i & ~wrh_prev_q;
    lo_rise    = en_i & ~cs_prev_q & wrl_n_s_i & ~wrl_prev_q;
    be_o       = {hi_rise, lo_rise};
    wr_o       = hi_rise | lo_rise;
    rd_o       = en_i & ~cs_n_s_i & ~rd_n_s_i & rd_prev_q;
    ale_fall_o = en_i & ale_prev_q & ~ale_s_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cs_prev_q  <= 1'b1;
      rd_prev_q  <= 1'b1;
      wrh_prev_q <= 1'b1;
      wrl_prev_q <= 1'b1;
      ale_prev_q <= 1'b0;
    end else begin
      cs_prev_q  <= cs_prev_d;
      rd_prev_q  <= rd_prev_d;
      wrh_prev_q <= wrh_prev_d;
      wrl_prev_q <= wrl_prev_d;
      ale_prev_q <= ale_prev_d;
    end
  end
endmodule

// File: rtl/cpubus_addr.sv
module cpubus_addr
  import cpubus_pkg::*;
#(
  parameter int ADDR_W = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mode_pin_i,
  input  logic              ale_fall_i,
  input  logic [ADDR_W-1:0] pin_addr_i,
  input  logic [ADDR_W-1:0] mux_addr_i,
  output bus_mode_e         mode_o,
  output logic              ready_o,
  output logic [ADDR_W-1:0] lat_o,
  output logic [ADDR_W-1:0] addr_o
);
  bus_mode_e         mode_q, mode_d;
  logic              ready_q, ready_d;
  logic [ADDR_W-1:0] lat_q, lat_d;
  logic              lat_en;

  always_comb begin
    mode_d  = mode_q;
    ready_d = 1'b1;
    if (!ready_q) mode_d = bus_mode_e'(mode_pin_i);
    lat_en = ready_q && (mode_q == MODE_MUXED) && ale_fall_i;
    lat_d  = lat_en ? mux_addr_i : lat_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q  <= MODE_SPLIT;
      ready_q <= 1'b0;
      lat_q   <= '0;
    end else begin
      mode_q  <= mode_d;
      ready_q <= ready_d;
      lat_q   <= lat_d;
    end
  end

  assign mode_o  = mode_q;
  assign ready_o = ready_q;
  assign lat_o   = lat_q;
  assign addr_o  = (mode_q == MODE_MUXED) ? lat_q : pin_addr_i;
endmodule

// File: rtl/cpubus_regfile.sv
module cpubus_regfile #(
  parameter int BYTE_W = 8,
  parameter int LANES  = 2,
  parameter int ADDR_W = 7,
  parameter int DEPTH  = 64
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      we_i,
  input  logic [LANES-1:0]          be_i,
  input  logic [ADDR_W-1:0]         addr_i,
  input  logic [LANES*BYTE_W-1:0]   wdata_i,
  output logic [LANES*BYTE_W-1:0]   rdata_o
);
  localparam int DATA_W = LANES * BYTE_W;
  localparam int IDX_W  = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [DEPTH-1:0][DATA_W-1:0] mem_q, mem_d;
  logic                         in_range;

  always_comb begin
    in_range = ({1'b0, addr_i} < (ADDR_W+1)'(DEPTH));
    mem_d    = mem_q;
    for (int w = 0; w < DEPTH; w++) begin
      for (int b = 0; b < LANES; b++) begin
        if (we_i && in_range && be_i[b] && (addr_i[IDX_W-1:0] == IDX_W'(w)))
          mem_d[w][b*BYTE_W +: BYTE_W] = wdata_i[b*BYTE_W +: BYTE_W];
      end
    end
    rdata_o = in_range ? mem_q[addr_i[IDX_W-1:0]] : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mem_q <= '0;
    else        mem_q <= mem_d;
  end
endmodule

// File: rtl/cpubus_bridge.sv
module cpubus_bridge
  import cpubus_pkg::*;
#(
  parameter int BYTE_W      = 8,
  parameter int ADDR_W      = 7,
  parameter int DEPTH       = 64,
  parameter int SYNC_STAGES = 2
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   mode_sel_i,
  input  logic                   bus_cs_n_i,
  input  logic                   bus_rd_n_i,
  input  logic                   bus_wrh_n_i,
  input  logic                   bus_wrl_n_i,
  input  logic [ADDR_W:1]        bus_a_i,
  input  logic [2*BYTE_W-1:0]    bus_d_i,
  output logic [2*BYTE_W-1:0]    bus_d_o,
  output logic                   bus_d_oe_o,
  output logic                   req_wr_o,
  output logic [1:0]             req_be_o,
  output logic                   req_rd_o,
  output logic [ADDR_W-1:0]      req_addr_o,
  output logic [2*BYTE_W-1:0]    req_wdata_o
);
  localparam int LANES  = 2;
  localparam int DATA_W = LANES * BYTE_W;

  logic rst_q_n;
  logic [3:0]        ctl_s;
  logic [ADDR_W-1:0] a_s;
  logic [DATA_W-1:0] d_s;

  cpubus_sync #(.WIDTH(1), .STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_rst_sync (
    .clk(clk), .rst_n(rst_n), .d_i(1'b1), .q_o(rst_q_n)
  );

  cpubus_sync #(.WIDTH(4), .STAGES(SYNC_STAGES), .RST_VAL(4'hF)) u_ctl_sync (
    .clk(clk), .rst_n(rst_q_n),
    .d_i({bus_cs_n_i, bus_rd_n_i, bus_wrh_n_i, bus_wrl_n_i}), .q_o(ctl_s)
  );

  cpubus_sync #(.WIDTH(ADDR_W), .STAGES(SYNC_STAGES), .RST_VAL('0)) u_a_sync (
    .clk(clk), .rst_n(rst_q_n), .d_i(bus_a_i), .q_o(a_s)
  );

  cpubus_sync #(.WIDTH(DATA_W), .STAGES(SYNC_STAGES), .RST_VAL('0)) u_d_sync (
    .clk(clk), .rst_n(rst_q_n), .d_i(bus_d_i), .q_o(d_s)
  );

  bus_mode_e         mode_w;
  logic              mode_rdy_w;
  logic              wr_p, rd_p, ale_fall_w;
  logic [1:0]        be_p;
  logic [ADDR_W-1:0] lat_w, addr_w;

  cpubus_strobe u_strobe (
    .clk(clk), .rst_n(rst_q_n), .en_i(mode_rdy_w),
    .cs_n_s_i(ctl_s[3]), .rd_n_s_i(ctl_s[2]),
    .wrh_n_s_i(ctl_s[1]), .wrl_n_s_i(ctl_s[0]),
    .ale_s_i(a_s[ADDR_W-1]),
    .wr_o(wr_p), .be_o(be_p), .rd_o(rd_p), .ale_fall_o(ale_fall_w)
  );

  cpubus_addr #(.ADDR_W(ADDR_W)) u_addr (
    .clk(clk), .rst_n(rst_q_n), .mode_pin_i(mode_sel_i),
    .ale_fall_i(ale_fall_w), .pin_addr_i(a_s),
    .mux_addr_i(d_s[ADDR_W:1]),
    .mode_o(mode_w), .ready_o(mode_rdy_w), .lat_o(lat_w), .addr_o(addr_w)
  );

  // request stage
  logic              wr_q, wr_d, rd_q, rd_d;
  logic [1:0]        be_q, be_d;
  logic [ADDR_W-1:0] addr_q, addr_d;
  logic [DATA_W-1:0] wdata_q, wdata_d, dout_q, dout_d;
  logic [DATA_W-1:0] rf_rdata;
  logic              req_en;

  always_comb begin
    req_en  = wr_p | rd_p;
    wr_d    = wr_p;
    rd_d    = rd_p;
    be_d    = be_p;
    addr_d  = req_en ? addr_w : addr_q;
    wdata_d = wr_p ? d_s : wdata_q;
    dout_d  = rd_q ? rf_rdata : dout_q;
  end

  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n) begin
      wr_q    <= 1'b0;
      rd_q    <= 1'b0;
      be_q    <= '0;
      addr_q  <= '0;
      wdata_q <= '0;
      dout_q  <= '0;
    end else begin
      wr_q    <= wr_d;
      rd_q    <= rd_d;
      be_q    <= be_d;
      addr_q  <= addr_d;
      wdata_q <= wdata_d;
      dout_q  <= dout_d;
    end
  end

  cpubus_regfile #(.BYTE_W(BYTE_W), .LANES(LANES), .ADDR_W(ADDR_W), .DEPTH(DEPTH)) u_rf (
    .clk(clk), .rst_n(rst_q_n), .we_i(wr_q), .be_i(be_q),
    .addr_i(addr_q), .wdata_i(wdata_q), .rdata_o(rf_rdata)
  );

  assign bus_d_oe_o  = ~bus_cs_n_i & ~bus_rd_n_i;
  assign bus_d_o     = dout_q;
  assign req_wr_o    = wr_q;
  assign req_be_o    = be_q;
  assign req_rd_o    = rd_q;
  assign req_addr_o  = addr_q;
  assign req_wdata_o = wdata_q;
endmodule

// File: rtl/cpubus_bridge_chk.sv
module cpubus_bridge_chk #(
  parameter int ADDR_W = 7
) (
  input logic              clk,
  input logic              rst_q_n,
  input logic              bus_cs_n_i,
  input logic              bus_rd_n_i,
  input logic              bus_d_oe_o,
  input logic              req_wr_o,
  input logic [1:0]        req_be_o,
  input logic              req_rd_o,
  input logic              mode_w,
  input logic              mode_rdy_w,
  input logic              ale_fall_w,
  input logic [ADDR_W-1:0] lat_w
);
  assert_wr_single_R8: assert property (@(posedge clk) disable iff (!rst_q_n)
    req_wr_o |=> !req_wr_o);
  assert_wr_mask_R8: assert property (@(posedge clk) disable iff (!rst_q_n)
    req_wr_o |-> (req_be_o != 2'b00));
  assert_rd_single_R12: assert property (@(posedge clk) disable iff (!rst_q_n)
    req_rd_o |=> !req_rd_o);
  assert_oe_cs_R4: assert property (@(posedge clk) disable iff (!rst_q_n)
    bus_cs_n_i |-> !bus_d_oe_o);
  assert_oe_rd_R5: assert property (@(posedge clk) disable iff (!rst_q_n)
    bus_rd_n_i |-> !bus_d_oe_o);
  assert_mode_fixed_R3: assert property (@(posedge clk) disable iff (!rst_q_n)
    mode_rdy_w |=> $stable(mode_w));
  assert_lat_hold_R9: assert property (@(posedge clk) disable iff (!rst_q_n)
    !ale_fall_w |=> $stable(lat_w));
endmodule

bind cpubus_bridge cpubus_bridge_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_q_n(rst_q_n), .bus_cs_n_i(bus_cs_n_i), .bus_rd_n_i(bus_rd_n_i),
  .bus_d_oe_o(bus_d_oe_o), .req_wr_o(req_wr_o), .req_be_o(req_be_o),
  .req_rd_o(req_rd_o), .mode_w(mode_w), .mode_rdy_w(mode_rdy_w),
  .ale_fall_w(ale_fall_w), .lat_w(lat_w)
);

// File: tb/cpubus_bridge_bench.sv
module cpubus_bridge_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        mode_sel_i = 1'b0;
  logic        bus_cs_n_i = 1'b1, bus_rd_n_i = 1'b1;
  logic        bus_wrh_n_i = 1'b1, bus_wrl_n_i = 1'b1;
  logic [7:1]  bus_a_i = '0;
  logic [15:0] bus_d_i = '0;
  logic [15:0] bus_d_o;
  logic        bus_d_oe_o, req_wr_o, req_rd_o;
  logic [1:0]  req_be_o;
  logic [6:0]  req_addr_o;
  logic [15:0] req_wdata_o;

  cpubus_bridge u_cpubus_bridge (
    .clk(clk), .rst_n(rst_n), .mode_sel_i(mode_sel_i),
    .bus_cs_n_i(bus_cs_n_i), .bus_rd_n_i(bus_rd_n_i),
    .bus_wrh_n_i(bus_wrh_n_i), .bus_wrl_n_i(bus_wrl_n_i),
    .bus_a_i(bus_a_i), .bus_d_i(bus_d_i), .bus_d_o(bus_d_o), .bus_d_oe_o(bus_d_oe_o),
    .req_wr_o(req_wr_o), .req_be_o(req_be_o), .req_rd_o(req_rd_o),
    .req_addr_o(req_addr_o), .req_wdata_o(req_wdata_o)
  );

  always #5 clk = ~clk;

  int checks = 0, fails = 0;
  logic [15:0] model [64];
  bit   muxed;
  int   wr_cnt = 0, rd_cnt = 0;
  logic [1:0]  last_be;
  logic [6:0]  last_addr;
  logic [15:0] last_data;

  always @(negedge clk) begin
    if (rst_n) begin
      if (req_wr_o) begin
        wr_cnt++;
        last_be = req_be_o; last_addr = req_addr_o; last_data = req_wdata_o;
      end
      if (req_rd_o) rd_cnt++;
    end
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  function automatic logic [15:0] expect_rd(input int adr);
    return (adr < 64) ? model[adr] : 16'h0000;
  endfunction

  task automatic do_reset(input bit m);
    rst_n = 1'b0; mode_sel_i = m; muxed = m;
    bus_cs_n_i = 1; bus_rd_n_i = 1; bus_wrh_n_i = 1; bus_wrl_n_i = 1; bus_a_i = '0;
    cyc(3);
    rst_n = 1'b1;
    cyc(5);
    for (int i = 0; i < 64; i++) model[i] = 16'h0;
    chk(!req_wr_o && !req_rd_o && !bus_d_oe_o, "R11 idle after reset",
        {req_wr_o, req_rd_o, bus_d_oe_o}, 0);
  endtask

  task automatic set_addr(input int adr, input bit d0);
    if (muxed) begin
      bus_a_i[6:1] = 6'($urandom);
      bus_d_i = {8'($urandom), adr[6:0], d0};
      bus_a_i[7] = 1'b1;
      cyc(3);
      bus_a_i[7] = 1'b0;
      cyc(4);
    end else begin
      bus_a_i = adr[6:0];
      cyc(1);
    end
  endtask

  task automatic bus_write(input int adr, input logic [15:0] dat, input bit hi, input bit lo,
                           input bit cs_on, input string req);
    int w0 = wr_cnt;
    bit exp_pulse = cs_on && (hi || lo);
    bus_cs_n_i = !cs_on;
    bus_d_i = dat;
    cyc(2);
    bus_wrh_n_i = !hi; bus_wrl_n_i = !lo;
    cyc(4);
    bus_wrh_n_i = 1; bus_wrl_n_i = 1;
    cyc(5);
    bus_cs_n_i = 1;
    cyc(2);
    chk(wr_cnt - w0 == int'(exp_pulse), {req, " R8 pulse count"}, wr_cnt - w0, int'(exp_pulse));
    if (exp_pulse) begin
      chk(last_be == {hi, lo} && last_addr == adr[6:0] && last_data == dat, {req, " R8 request fields"},
          {last_be, last_addr, last_data}, {hi, lo, adr[6:0], dat});
      if (adr < 64) begin
        if (hi) model[adr][15:8] = dat[15:8];
        if (lo) model[adr][7:0]  = dat[7:0];
      end
    end
  endtask

  task automatic bus_read(input int adr, input bit cs_on, input string req);
    int r0 = rd_cnt;
    bus_cs_n_i = !cs_on;
    cyc(1);
    bus_rd_n_i = 0;
    #1;
    chk(bus_d_oe_o == cs_on, {req, " R5 enable while reading"}, bus_d_oe_o, cs_on);
    cyc(8);
    if (cs_on) begin
      chk(bus_d_o == expect_rd(adr), {req, " read data"}, bus_d_o, expect_rd(adr));
    end
    chk(rd_cnt - r0 == int'(cs_on), {req, " R12 read pulse"}, rd_cnt - r0, int'(cs_on));
    bus_rd_n_i = 1;
    #1;
    chk(!bus_d_oe_o, {req, " R5 released"}, bus_d_oe_o, 0);
    cyc(1);
    bus_cs_n_i = 1;
    cyc(2);
  endtask

  task automatic random_ops(input int n, input string req);
    int lat = 0;
    for (int k = 0; k < n; k++) begin
      int adr = int'($urandom_range(0, 127));
      int bsel = int'($urandom_range(1, 3));
      bit reuse = muxed && ($urandom_range(0, 3) == 0) && (k > 0);
      if (reuse) adr = lat;
      else begin set_addr(adr, 1'($urandom)); lat = adr; end
      if ($urandom_range(0, 1) == 1)
        bus_write(adr, 16'($urandom), bsel[1], bsel[0], 1'b1, req);
      else
        bus_read(adr, 1'b1, req);
    end
  endtask

  initial begin
    void'($urandom(32'h0001_5EED));
    // ---------------- split mode ----------------
    do_reset(1'b0);
    set_addr(3, 0);
    bus_write(3, 16'hA5C3, 1, 1, 1, "R1");
    bus_read(3, 1, "R1");
    bus_write(3, 16'h1100, 1, 0, 1, "R6");
    bus_read(3, 1, "R6");
    bus_write(3, 16'h0022, 0, 1, 1, "R7");
    bus_read(3, 1, "R7");
    set_addr(67, 0);
    bus_write(67, 16'hFFFF, 1, 1, 1, "R10");
    bus_read(67, 1, "R10");
    set_addr(3, 0);
    bus_read(3, 1, "R10 alias untouched");
    bus_write(3, 16'hDEAD, 1, 1, 0, "R4");
    bus_read(3, 1, "R4 word unchanged");
    bus_read(3, 0, "R4 no enable without select");
    mode_sel_i = 1'b1;
    set_addr(10, 0);
    bus_write(10, 16'h3C5A, 1, 1, 1, "R3");
    bus_read(10, 1, "R3");
    random_ops(120, "R1 random");
    // ---------------- muxed mode ----------------
    do_reset(1'b1);
    bus_a_i[7] = 1'b0;
    cyc(2);
    set_addr(3, 0);
    bus_read(3, 1, "R11 cleared");
    set_addr(5, 1);
    bus_write(5, 16'h7E81, 1, 1, 1, "R2");
    set_addr(5, 0);
    bus_read(5, 1, "R2 bit0 ignored");
    set_addr(9, 0);
    bus_write(9, 16'h1234, 1, 1, 1, "R9");
    bus_write(9, 16'hAB00, 1, 0, 1, "R9");
    bus_read(9, 1, "R9 held address");
    bus_read(9, 1, "R9 held address again");
    mode_sel_i = 1'b0;
    set_addr(20, 0);
    bus_write(20, 16'h0F0F, 1, 1, 1, "R3 muxed");
    bus_read(20, 1, "R3 muxed");
    random_ops(120, "R2 random");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=timeout expected=completion");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule